// File: doc/BRIEF.md
# Machine-Mode Control Register Unit

This unit holds the five 32-bit machine control registers of a small processor core: interrupt enable, exception return address, trap vector base, trap cause and a scratch word. Each register has a fixed 12-bit control-register address. When the core retires a control-register instruction, it presents an address, an operation code and two operands: a register operand and an immediate that is already zero-extended. The unit then performs a read-modify-write on the selected register. The old value can be read combinationally in the same cycle, and the new value appears after the clock edge.

On trap entry the core raises a trap strobe. On the next edge the unit captures the faulting PC into the exception-address register and the trap cause into the cause register, both in the same cycle. Trap capture takes precedence over any software write in that cycle. Three of the registers (interrupt enable, exception address and trap vector) also drive dedicated outputs at all times, so that interrupt and redirect logic elsewhere can use them without an address.

Top module: `mcsr_unit`

## Requirements
- R1: A synchronous, active-high reset clears all five registers to zero.
- R2: The addresses are 0x304 interrupt enable, 0x305 trap vector, 0x340 scratch, 0x341 exception address and 0x342 cause. `rdData` is a combinational copy of the addressed register. Any other address reads as zero, and a write to it changes nothing.
- R3: A register changes only on an edge where `wrEn` or `trapIn` is high. A written value is visible on `rdData` once that edge has passed.
- R4: `opCode` 3'b001 (register operand) and 3'b101 (immediate operand) replace the register with the operand.
- R5: `opCode` 3'b010 and 3'b110 OR the operand into the register. A zero operand leaves the register unchanged, which makes the operation a pure read.
- R6: `opCode` 3'b011 and 3'b111 clear the register bits where the operand is one, by ANDing the register with the inverted operand.
- R7: `opCode` bit 2 selects `immOperand` when it is 1 and `regOperand` when it is 0. The codes 3'b000 and 3'b100 write nothing, even when `wrEn` is high.
- R8: When `trapIn` is high, the next edge loads `pcIn` into the exception-address register and `causeIn` into the cause register.
- R9: A software write in the same cycle as `trapIn` is discarded, whichever register it targets.
- R10: `intEnableOut`, `excPcOut` and `trapVecOut` always show their registers, whatever `csrAddr` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trapIn | input | 1 | Trap entry strobe |
| opCode | input | 3 | Read-modify-write operation code |
| csrAddr | input | 12 | Control-register address |
| pcIn | input | 32 | PC to capture on trap |
| causeIn | input | 32 | Cause to capture on trap |
| regOperand | input | 32 | Register-file operand |
| immOperand | input | 32 | Zero-extended immediate operand |
| wrEn | input | 1 | Software write enable |
| rdData | output | 32 | Addressed register value |
| intEnableOut | output | 32 | Interrupt enable register |
| excPcOut | output | 32 | Exception address register |
| trapVecOut | output | 32 | Trap vector register |

## Verification
The bench targets the cases where a plausible design goes wrong:
- A trap that lands in the same cycle as a software write to the scratch or exception-address register. A design that lets the write win, or that blocks it only for the trapped registers, leaves the software value in place.
- Set and clear with a zero operand, and the idle codes 000 and 100 with the write enable high. A wrong decode corrupts the register instead of leaving it untouched.
- A write to an unmapped address. An incomplete decode lets it spill into a real register, or makes an unmapped read return a stale value.
- The immediate variants, together with a write-enable-low cycle. A swapped operand select or a missing enable shows up there.

// File: rtl/mcsr_pkg.sv
package mcsr_pkg;

  localparam int NUM_REGS = 5;

  // Register slots; the trap path depends on the two capture slots.
  localparam int IDX_IE    = 0;
  localparam int IDX_TV    = 1;
  localparam int IDX_SCR   = 2;
  localparam int IDX_EPC   = 3;
  localparam int IDX_CAUSE = 4;

  typedef enum logic [1:0] {
    RMW_NONE  = 2'b00,
    RMW_WRITE = 2'b01,
    RMW_SET   = 2'b10,
    RMW_CLEAR = 2'b11
  } rmw_e;

  typedef struct packed {
    logic [NUM_REGS-1:0] sel;
    logic [NUM_REGS-1:0] wrStrobe;
    logic                trapLoad;
    logic                useImm;
    rmw_e                kind;
  } ctrl_s;

  function automatic logic [11:0] regAddr(input int idx);
    case (idx)
      IDX_IE:    regAddr = 12'h304;
      IDX_TV:    regAddr = 12'h305;
      IDX_SCR:   regAddr = 12'h340;
      IDX_EPC:   regAddr = 12'h341;
      IDX_CAUSE: regAddr = 12'h342;
      default:   regAddr = 12'h000;
    endcase
  endfunction

endpackage

// File: rtl/mcsr_ctrl.sv
module mcsr_ctrl
  import mcsr_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              wrEn,
  input  logic              trapIn,
  input  logic [2:0]        opCode,
  input  logic [ADDR_W-1:0] csrAddr,
  output ctrl_s             ctrl
);

  logic [NUM_REGS-1:0] selVec;
  logic                swWrite;
  rmw_e                kindDec;

  // One comparator per register slot.
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
    assign selVec[i] = (csrAddr == ADDR_W'(regAddr(i)));
  end

  assign kindDec = rmw_e'(opCode[1:0]);

  // A trap cancels every software write in its cycle (R9).
  assign swWrite = wrEn && (kindDec != RMW_NONE) && !trapIn;

  always_comb begin
    ctrl          = '0;
    ctrl.sel      = selVec;
    ctrl.wrStrobe = selVec & {NUM_REGS{swWrite}};
    ctrl.trapLoad = trapIn;
    ctrl.useImm   = opCode[2];
    ctrl.kind     = kindDec;
  end

endmodule

// File: rtl/mcsr_datapath.sv
module mcsr_datapath
  import mcsr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrl_s             ctrl,
  input  logic [DATA_W-1:0] regOperand,
  input  logic [DATA_W-1:0] immOperand,
  input  logic [DATA_W-1:0] pcIn,
  input  logic [DATA_W-1:0] causeIn,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] intEnableOut,
  output logic [DATA_W-1:0] excPcOut,
  output logic [DATA_W-1:0] trapVecOut
);

  logic [DATA_W-1:0] regQ [NUM_REGS];
  logic [DATA_W-1:0] operand;

  assign operand = ctrl.useImm ? immOperand : regOperand;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [DATA_W-1:0] swNext;
    logic [DATA_W-1:0] trapVal;
    logic              trapHit;

    always_comb begin
      case (ctrl.kind)
        RMW_WRITE: swNext = operand;
        RMW_SET:   swNext = regQ[i] | operand;
        RMW_CLEAR: swNext = regQ[i] & ~operand;
        default:   swNext = regQ[i];
      endcase
    end

    if (i == IDX_EPC) begin : g_trap_pc
      assign trapVal = pcIn;
      assign trapHit = ctrl.trapLoad;
    end else if (i == IDX_CAUSE) begin : g_trap_cause
      assign trapVal = causeIn;
      assign trapHit = ctrl.trapLoad;
    end else begin : g_no_trap
      assign trapVal = '0;
      assign trapHit = 1'b0;
    end

    always_ff @(posedge clk) begin
      if (rst)                  regQ[i] <= '0;
      else if (trapHit)         regQ[i] <= trapVal;
      else if (ctrl.wrStrobe[i]) regQ[i] <= swNext;
    end
  end

  // AND-OR read multiplexer; an unmapped address selects nothing.
  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      rdData = rdData | (regQ[i] & {DATA_W{ctrl.sel[i]}});
    end
  end

  assign intEnableOut = regQ[IDX_IE];
  assign excPcOut     = regQ[IDX_EPC];
  assign trapVecOut   = regQ[IDX_TV];

endmodule

// File: rtl/mcsr_unit.sv
module mcsr_unit
  import mcsr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trapIn,
  input  logic [2:0]        opCode,
  input  logic [ADDR_W-1:0] csrAddr,
  input  logic [DATA_W-1:0] pcIn,
  input  logic [DATA_W-1:0] causeIn,
  input  logic [DATA_W-1:0] regOperand,
  input  logic [DATA_W-1:0] immOperand,
  input  logic              wrEn,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] intEnableOut,
  output logic [DATA_W-1:0] excPcOut,
  output logic [DATA_W-1:0] trapVecOut
);

  ctrl_s ctrl;

  mcsr_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .wrEn    (wrEn),
    .trapIn  (trapIn),
    .opCode  (opCode),
    .csrAddr (csrAddr),
    .ctrl    (ctrl)
  );

  mcsr_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk          (clk),
    .rst          (rst),
    .ctrl         (ctrl),
    .regOperand   (regOperand),
    .immOperand   (immOperand),
    .pcIn         (pcIn),
    .causeIn      (causeIn),
    .rdData       (rdData),
    .intEnableOut (intEnableOut),
    .excPcOut     (excPcOut),
    .trapVecOut   (trapVecOut)
  );

endmodule

// File: rtl/mcsr_unit_chk.sv
module mcsr_unit_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              trapIn,
  input logic [2:0]        opCode,
  input logic [ADDR_W-1:0] csrAddr,
  input logic [DATA_W-1:0] pcIn,
  input logic [DATA_W-1:0] causeIn,
  input logic [DATA_W-1:0] regOperand,
  input logic              wrEn,
  input logic [DATA_W-1:0] rdData,
  input logic [DATA_W-1:0] intEnableOut,
  input logic [DATA_W-1:0] excPcOut,
  input logic [DATA_W-1:0] trapVecOut
);

  logic mapped;
  assign mapped = (csrAddr == ADDR_W'(12'h304)) || (csrAddr == ADDR_W'(12'h305)) ||
                  (csrAddr == ADDR_W'(12'h340)) || (csrAddr == ADDR_W'(12'h341)) ||
                  (csrAddr == ADDR_W'(12'h342));

  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> (intEnableOut == '0 && excPcOut == '0 && trapVecOut == '0 &&
                    (!rst || rdData == '0)));

  p_unmapped_zero_r2: assert property (@(posedge clk) disable iff (rst)
    !mapped |-> rdData == '0);

  p_hold_idle_r3: assert property (@(posedge clk) disable iff (rst)
    (!wrEn && !trapIn) |=> ($stable(intEnableOut) && $stable(excPcOut) && $stable(trapVecOut)));

  p_write_ie_r4: assert property (@(posedge clk) disable iff (rst)
    (wrEn && !trapIn && opCode == 3'b001 && csrAddr == ADDR_W'(12'h304))
      |=> intEnableOut == $past(regOperand));

  p_set_tv_r5: assert property (@(posedge clk) disable iff (rst)
    (wrEn && !trapIn && opCode == 3'b010 && csrAddr == ADDR_W'(12'h305))
      |=> trapVecOut == ($past(trapVecOut) | $past(regOperand)));

  p_trap_pc_r8: assert property (@(posedge clk) disable iff (rst)
    trapIn |=> excPcOut == $past(pcIn));

  p_trap_cause_r8: assert property (@(posedge clk) disable iff (rst)
    (trapIn && csrAddr == ADDR_W'(12'h342))
      |=> (csrAddr != ADDR_W'(12'h342) || rdData == $past(causeIn)));

  p_trap_wins_r9: assert property (@(posedge clk) disable iff (rst)
    trapIn |=> ($stable(intEnableOut) && $stable(trapVecOut)));

endmodule

bind mcsr_unit mcsr_unit_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .trapIn       (trapIn),
  .opCode       (opCode),
  .csrAddr      (csrAddr),
  .pcIn         (pcIn),
  .causeIn      (causeIn),
  .regOperand   (regOperand),
  .wrEn         (wrEn),
  .rdData       (rdData),
  .intEnableOut (intEnableOut),
  .excPcOut     (excPcOut),
  .trapVecOut   (trapVecOut)
);

// File: tb/sim_mcsr_unit.sv
module sim_mcsr_unit;

  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        trapIn = 1'b0;
  logic [2:0]  opCode = '0;
  logic [11:0] csrAddr = '0;
  logic [31:0] pcIn = '0;
  logic [31:0] causeIn = '0;
  logic [31:0] regOperand = '0;
  logic [31:0] immOperand = '0;
  logic        wrEn = 1'b0;
  logic [31:0] rdData, intEnableOut, excPcOut, trapVecOut;

  mcsr_unit u0 (
    .clk(clk), .rst(rst), .trapIn(trapIn), .opCode(opCode), .csrAddr(csrAddr),
    .pcIn(pcIn), .causeIn(causeIn), .regOperand(regOperand), .immOperand(immOperand),
    .wrEn(wrEn), .rdData(rdData), .intEnableOut(intEnableOut), .excPcOut(excPcOut),
    .trapVecOut(trapVecOut)
  );

  always #(PERIOD/2) clk = ~clk;

  typedef struct {
    logic [31:0] rd;
    logic [31:0] ie;
    logic [31:0] epc;
    logic [31:0] tv;
    string       req;
  } exp_t;

  exp_t        sbq[$];
  logic [31:0] model [5];
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  // Model slots: 0 enable, 1 vector, 2 scratch, 3 exception address, 4 cause
  function automatic int idxOf(input logic [11:0] a);
    case (a)
      12'h304: idxOf = 0;
      12'h305: idxOf = 1;
      12'h340: idxOf = 2;
      12'h341: idxOf = 3;
      12'h342: idxOf = 4;
      default: idxOf = -1;
    endcase
  endfunction

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; wrEn = 1'b0; trapIn = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 5; i++) model[i] = '0;
  endtask

  task automatic doOp(input logic [2:0] op, input logic [11:0] a, input logic [31:0] rv,
                      input logic [31:0] iv, input logic we, input logic tr,
                      input logic [31:0] pc, input logic [31:0] cause);
    int k;
    logic [31:0] opnd;
    @(negedge clk);
    opCode = op; csrAddr = a; regOperand = rv; immOperand = iv;
    wrEn = we; trapIn = tr; pcIn = pc; causeIn = cause;
    @(posedge clk);
    k = idxOf(a);
    opnd = op[2] ? iv : rv;
    if (tr) begin
      model[3] = pc;
      model[4] = cause;
    end else if (we && k >= 0) begin
      case (op[1:0])
        2'b01:   model[k] = opnd;
        2'b10:   model[k] = model[k] | opnd;
        2'b11:   model[k] = model[k] & ~opnd;
        default: ;
      endcase
    end
  endtask

  task automatic readChk(input logic [11:0] a, input string req);
    exp_t e;
    int k;
    @(negedge clk);
    wrEn = 1'b0; trapIn = 1'b0; csrAddr = a;
    k = idxOf(a);
    e.rd  = (k >= 0) ? model[k] : 32'h0;
    e.ie  = model[0];
    e.epc = model[3];
    e.tv  = model[1];
    e.req = req;
    sbq.push_back(e);
    @(posedge clk);
  endtask

  task automatic readAll(input string req);
    readChk(12'h304, req);
    readChk(12'h305, req);
    readChk(12'h340, req);
    readChk(12'h341, req);
    readChk(12'h342, req);
  endtask

  // Monitor: pop one expected item per read cycle and compare.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sbq.size() > 0) begin
        exp_t e;
        e = sbq.pop_front();
        checks++;
        if (rdData !== e.rd) begin
          errors++;
          $display("FAIL %s rdData actual=%h expected=%h", e.req, rdData, e.rd);
        end
        checks++;
        if (intEnableOut !== e.ie || excPcOut !== e.epc || trapVecOut !== e.tv) begin
          errors++;
          $display("FAIL R10 dedicated outputs actual=%h/%h/%h expected=%h/%h/%h",
                   intEnableOut, excPcOut, trapVecOut, e.ie, e.epc, e.tv);
        end
      end
    end
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL R3 watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    doReset();
    // R1: all registers zero after reset; R2: unmapped read zero
    readAll("R1");
    readChk(12'h300, "R2");

    // R4: register-operand replace on every register
    doOp(3'b001, 12'h304, 32'hA5A5_0F0F, 32'h0, 1, 0, 0, 0);
    doOp(3'b001, 12'h305, 32'h8000_0100, 32'h0, 1, 0, 0, 0);
    doOp(3'b001, 12'h340, 32'h1234_5678, 32'h0, 1, 0, 0, 0);
    doOp(3'b001, 12'h341, 32'hDEAD_BEEF, 32'h0, 1, 0, 0, 0);
    doOp(3'b001, 12'h342, 32'h0000_000B, 32'h0, 1, 0, 0, 0);
    readAll("R4");
    // R10: dedicated outputs while address points elsewhere
    readChk(12'h7FF, "R10");

    // R7 and R4: immediate replace takes immOperand, not regOperand
    doOp(3'b101, 12'h340, 32'hFFFF_FFFF, 32'h0000_0015, 1, 0, 0, 0);
    readChk(12'h340, "R7");

    // R5: set with register operand, with zero operand, and with immediate
    doOp(3'b010, 12'h305, 32'h0000_00F0, 32'h0, 1, 0, 0, 0);
    readChk(12'h305, "R5");
    doOp(3'b010, 12'h304, 32'h0, 32'h0000_001F, 1, 0, 0, 0);
    readChk(12'h304, "R5");
    doOp(3'b110, 12'h340, 32'hFFFF_0000, 32'h0000_000A, 1, 0, 0, 0);
    readChk(12'h340, "R5");

    // R6: clear with register operand and with immediate
    doOp(3'b011, 12'h304, 32'h0000_0F00, 32'h0, 1, 0, 0, 0);
    readChk(12'h304, "R6");
    doOp(3'b111, 12'h341, 32'hFFFF_FFFF, 32'h0000_000F, 1, 0, 0, 0);
    readChk(12'h341, "R6");

    // R7: idle codes write nothing even with enable high
    doOp(3'b000, 12'h304, 32'h1111_1111, 32'h1F, 1, 0, 0, 0);
    doOp(3'b100, 12'h304, 32'h2222_2222, 32'h1F, 1, 0, 0, 0);
    readChk(12'h304, "R7");

    // R3: no enable means no change
    doOp(3'b001, 12'h305, 32'h5555_5555, 32'h0, 0, 0, 0, 0);
    readChk(12'h305, "R3");

    // R8: trap captures PC and cause
    doOp(3'b000, 12'h342, 32'h0, 32'h0, 0, 1, 32'h0000_2040, 32'h8000_0007);
    readChk(12'h342, "R8");
    readChk(12'h341, "R8");

    // R9: trap beats simultaneous software writes
    doOp(3'b001, 12'h340, 32'hCAFE_F00D, 32'h0, 1, 1, 32'h0000_3000, 32'h0000_0002);
    readChk(12'h340, "R9");
    readChk(12'h342, "R9");
    doOp(3'b001, 12'h341, 32'hBAD0_BAD0, 32'h0, 1, 1, 32'h0000_3100, 32'h0000_0003);
    readChk(12'h341, "R9");

    // R2: write to an unmapped address touches nothing
    doOp(3'b001, 12'h300, 32'hFFFF_FFFF, 32'h0, 1, 0, 0, 0);
    readAll("R2");

    // Mixed operations across all registers (R4 R5 R6 R7)
    for (int n = 0; n < 40; n++) begin
      logic [2:0] ops [6];
      logic [11:0] adr [5];
      logic [2:0] op;
      logic [11:0] a;
      ops = '{3'b001, 3'b010, 3'b011, 3'b101, 3'b110, 3'b111};
      adr = '{12'h304, 12'h305, 12'h340, 12'h341, 12'h342};
      op = ops[$urandom_range(5)];
      a  = adr[$urandom_range(4)];
      doOp(op, a, $urandom, {27'h0, 5'($urandom)}, 1, 0, 0, 0);
      readChk(a, "R5");
    end

    // R1: reset in the middle of activity
    doReset();
    readAll("R1");

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule